// File: doc/BRIEF.md
# Prioritized Nested Interrupt Controller

This block collects a set of peripheral interrupt lines and one non-maskable line. For every line it holds a pending flag, an active flag, an enable flag and a 4-bit urgency value. A numerically smaller value is more urgent. Each cycle it picks the most urgent enabled pending line and checks whether that line may preempt the handlers already running. If it may, the block presents the line's number to the core as a registered request.

The core accepts a request with an entry strobe. It reports a finished handler with an exit strobe that carries the handler's number. Software reaches the block through a one-cycle write port. The write port can:
- set or clear pending flags by bit mask;
- set or clear enable flags by bit mask;
- load one line's urgency;
- pend one line by number, as a software trigger;
- move the split between the group field and the subpriority field.

When a handler exits and another request qualifies, the request appears in the very next cycle. It carries a chaining flag, so the core can go straight into the next handler.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, req_valid and req_tail are 0. Reset also clears every pending, active and enable flag, every urgency value and the split field.
- R2: A line whose input is sampled high while it is not active becomes pending. If it is enabled and nothing is running, it is presented two clock edges after the input rises. req_id is the line number.
- R3: A rising edge on an input pends the line even while that line is active.
- R4: Write ops on wr_op:
  - 0 sets the pending flags selected by the wr_data mask.
  - 1 clears the pending flags selected by the mask.
  - 2 sets the enable flags selected by the mask.
  - 3 clears the enable flags selected by the mask.
  - 4 loads wr_val[3:0] as the urgency of line wr_num.
  - 5 pends line wr_num (software trigger).
  - 6 loads wr_val[2:0] into the split field.
- R5: An entry strobe taken while req_valid is high has three effects on the presented line: its pending flag is cleared, its active flag is set, and req_valid is 0 in the next cycle. A line held high while active does not pend again by level. If the line drops before exit, it is not presented again.
- R6: If a line's input is still high in the cycle its exit strobe is taken, the line is pending again at once.
- R7: Among enabled pending lines, the smallest urgency value wins. Ties go to the lowest line number.
- R8: The split field S gives min(S, 3) subpriority bits, which is the low part of the urgency. The remaining high part is the group. A candidate is presented over running handlers only if its group is strictly smaller than the smallest group among the active lines. For example, split 7 leaves one group bit.
- R9: A request that becomes presentable through an exit is presented in the cycle right after the exit edge, with req_tail set to 1. req_tail is 0 otherwise.
- R10: The non-maskable line is presented as id NUM_IRQ. It needs no enable and is chosen over every other line. While it is active, nothing is presented. An edge during that time is kept pending for after its exit.
- R11: A disabled line still pends but is never presented. Once enabled, it is presented.
- R12: A changed urgency value is used by the arbitration in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_IRQ | Peripheral interrupt lines |
| nmi_in | input | 1 | Non-maskable interrupt line |
| wr_en | input | 1 | Write strobe |
| wr_op | input | 3 | Write operation code (R4) |
| wr_num | input | ID_W | Line number for urgency load and software trigger |
| wr_data | input | NUM_IRQ | Bit mask for pending and enable ops |
| wr_val | input | VAL_W | Urgency value or split field |
| core_ack | input | 1 | Handler entry strobe for the presented request |
| core_exit | input | 1 | Handler exit strobe |
| exit_id | input | ID_W | Number of the exiting handler |
| req_valid | output | 1 | A request is presented |
| req_id | output | ID_W | Number of the presented request |
| req_tail | output | 1 | The request follows an exit directly |

## Verification
The bench builds the block with eight lines and 4-bit urgency values. With this size, every pair of lines can be raced against each other with urgency values computed from the pair indices, including forced ties. The small line count also lets the nesting scenarios, the split clamp and the non-maskable interplay run as short directed sequences. Expected winners, presentation cycles and chaining flags come from the arithmetic of the requirements.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  typedef enum logic [2:0] {
    OP_PEND_SET = 3'd0,
    OP_PEND_CLR = 3'd1,
    OP_EN_SET   = 3'd2,
    OP_EN_CLR   = 3'd3,
    OP_PRIO     = 3'd4,
    OP_TRIG     = 3'd5,
    OP_SPLIT    = 3'd6,
    OP_NONE     = 3'd7
  } wr_op_e;
endpackage

// File: rtl/irq_line_bank.sv
module irq_line_bank #(
  parameter int NUM_IRQ = 41
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic [NUM_IRQ-1:0] sw_set,
  input  logic [NUM_IRQ-1:0] sw_clr,
  input  logic [NUM_IRQ-1:0] en_set,
  input  logic [NUM_IRQ-1:0] en_clr,
  input  logic [NUM_IRQ-1:0] entry_vec,
  input  logic [NUM_IRQ-1:0] exit_vec,
  output logic [NUM_IRQ-1:0] pend,
  output logic [NUM_IRQ-1:0] act,
  output logic [NUM_IRQ-1:0] en
);
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    logic in_q;
    logic rise;
    logic hw_set;

    assign rise   = irq_in[i] & ~in_q;
    assign hw_set = (irq_in[i] & ~act[i]) | rise | (irq_in[i] & exit_vec[i]);

    always_ff @(posedge clk) begin
      if (rst) begin
        in_q    <= 1'b0;
        pend[i] <= 1'b0;
        act[i]  <= 1'b0;
        en[i]   <= 1'b0;
      end else begin
        in_q    <= irq_in[i];
        pend[i] <= (pend[i] | hw_set | sw_set[i]) & ~(sw_clr[i] | entry_vec[i]);
        act[i]  <= (act[i] | entry_vec[i]) & ~exit_vec[i];
        en[i]   <= (en[i] | en_set[i]) & ~en_clr[i];
      end
    end
  end
endmodule

// File: rtl/irq_prio_regs.sv
module irq_prio_regs #(
  parameter int NUM_IRQ = 41,
  parameter int PRIO_W  = 4,
  parameter int ID_W    = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [ID_W-1:0]           waddr,
  input  logic [PRIO_W-1:0]         wdata,
  output logic [NUM_IRQ*PRIO_W-1:0] prio_flat
);
  logic [PRIO_W-1:0] prio_q [NUM_IRQ];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_IRQ; i++) prio_q[i] <= '0;
    end else if (we) begin
      for (int i = 0; i < NUM_IRQ; i++)
        if (waddr == ID_W'(i)) prio_q[i] <= wdata;
    end
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_flat
    assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NUM_IRQ = 41,
  parameter int PRIO_W  = 4,
  parameter int ID_W    = 6
) (
  input  logic [NUM_IRQ-1:0]        cand,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
  output logic                      found,
  output logic [ID_W-1:0]           best_id,
  output logic [PRIO_W-1:0]         best_prio
);
  logic [NUM_IRQ:0]  f_c;
  logic [PRIO_W-1:0] p_c  [NUM_IRQ+1];
  logic [ID_W-1:0]   id_c [NUM_IRQ+1];

  assign f_c[0]  = 1'b0;
  assign p_c[0]  = '1;
  assign id_c[0] = '0;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_stage
    logic [PRIO_W-1:0] pr;
    logic take;
    assign pr   = prio_flat[i*PRIO_W +: PRIO_W];
    assign take = cand[i] && (!f_c[i] || (pr < p_c[i]));
    assign f_c[i+1]  = f_c[i] | cand[i];
    assign p_c[i+1]  = take ? pr : p_c[i];
    assign id_c[i+1] = take ? ID_W'(i) : id_c[i];
  end

  assign found     = f_c[NUM_IRQ];
  assign best_id   = id_c[NUM_IRQ];
  assign best_prio = p_c[NUM_IRQ];
endmodule

// File: rtl/irq_run_level.sv
module irq_run_level #(
  parameter int NUM_IRQ = 41,
  parameter int PRIO_W  = 4
) (
  input  logic [NUM_IRQ-1:0]        act,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
  input  logic [2:0]                sub_bits,
  output logic [PRIO_W:0]           run_group
);
  logic [PRIO_W:0] g_c [NUM_IRQ+1];

  assign g_c[0] = {1'b1, {PRIO_W{1'b0}}};

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_stage
    logic [PRIO_W:0] grp;
    assign grp      = {1'b0, prio_flat[i*PRIO_W +: PRIO_W]} >> sub_bits;
    assign g_c[i+1] = (act[i] && (grp < g_c[i])) ? grp : g_c[i];
  end

  assign run_group = g_c[NUM_IRQ];
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_IRQ = 41,
  parameter int PRIO_W  = 4,
  localparam int ID_W   = $clog2(NUM_IRQ + 1),
  localparam int VAL_W  = (PRIO_W > 3) ? PRIO_W : 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               nmi_in,
  input  logic               wr_en,
  input  logic [2:0]         wr_op,
  input  logic [ID_W-1:0]    wr_num,
  input  logic [NUM_IRQ-1:0] wr_data,
  input  logic [VAL_W-1:0]   wr_val,
  input  logic               core_ack,
  input  logic               core_exit,
  input  logic [ID_W-1:0]    exit_id,
  output logic               req_valid,
  output logic [ID_W-1:0]    req_id,
  output logic               req_tail
);
  localparam int MAX_SUB = PRIO_W - 1;
  localparam logic [ID_W-1:0] NMI_ID = ID_W'(NUM_IRQ);

  wr_op_e op;
  assign op = wr_op_e'(wr_op);

  logic [NUM_IRQ-1:0] sw_set, sw_clr, en_set, en_clr, entry_vec, exit_vec;
  logic [NUM_IRQ-1:0] line_pend, line_act, line_en;
  logic [NUM_IRQ*PRIO_W-1:0] prio_flat;
  logic [2:0] split_q, sub_bits;
  logic nmi_q, nmi_pend_q, nmi_act_q;
  logic req_valid_q, req_tail_q, exit_seen_q;
  logic [ID_W-1:0] req_id_q;

  always_comb begin
    for (int i = 0; i < NUM_IRQ; i++) begin
      sw_set[i]    = wr_en && ((op == OP_PEND_SET && wr_data[i]) ||
                               (op == OP_TRIG && wr_num == ID_W'(i)));
      sw_clr[i]    = wr_en && op == OP_PEND_CLR && wr_data[i];
      en_set[i]    = wr_en && op == OP_EN_SET && wr_data[i];
      en_clr[i]    = wr_en && op == OP_EN_CLR && wr_data[i];
      entry_vec[i] = core_ack && req_valid_q && req_id_q == ID_W'(i);
      exit_vec[i]  = core_exit && exit_id == ID_W'(i);
    end
  end

  irq_line_bank #(.NUM_IRQ(NUM_IRQ)) u_lines (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .sw_set(sw_set), .sw_clr(sw_clr), .en_set(en_set), .en_clr(en_clr),
    .entry_vec(entry_vec), .exit_vec(exit_vec),
    .pend(line_pend), .act(line_act), .en(line_en)
  );

  irq_prio_regs #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_prio (
    .clk(clk), .rst(rst),
    .we(wr_en && op == OP_PRIO && wr_num < NMI_ID),
    .waddr(wr_num), .wdata(wr_val[PRIO_W-1:0]), .prio_flat(prio_flat)
  );

  always_ff @(posedge clk) begin
    if (rst) split_q <= '0;
    else if (wr_en && op == OP_SPLIT) split_q <= wr_val[2:0];
  end

  assign sub_bits = (int'(split_q) > MAX_SUB) ? 3'(MAX_SUB) : split_q;

  logic found;
  logic [ID_W-1:0] best_id;
  logic [PRIO_W-1:0] best_prio;
  logic [PRIO_W:0] run_group, best_group;

  irq_arbiter #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
    .cand(line_pend & line_en), .prio_flat(prio_flat),
    .found(found), .best_id(best_id), .best_prio(best_prio)
  );

  irq_run_level #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_run (
    .act(line_act), .prio_flat(prio_flat), .sub_bits(sub_bits),
    .run_group(run_group)
  );

  assign best_group = {1'b0, best_prio} >> sub_bits;

  // Non-maskable line: pends on high level while idle or on a rising edge.
  logic nmi_entry, nmi_exit;
  assign nmi_entry = core_ack && req_valid_q && req_id_q == NMI_ID;
  assign nmi_exit  = core_exit && exit_id == NMI_ID;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_q      <= 1'b0;
      nmi_pend_q <= 1'b0;
      nmi_act_q  <= 1'b0;
    end else begin
      nmi_q      <= nmi_in;
      nmi_pend_q <= (nmi_pend_q | (nmi_in & ~nmi_act_q) | (nmi_in & ~nmi_q) |
                     (nmi_in & nmi_exit)) & ~nmi_entry;
      nmi_act_q  <= (nmi_act_q | nmi_entry) & ~nmi_exit;
    end
  end

  logic valid_nxt;
  logic [ID_W-1:0] id_nxt;

  always_comb begin
    valid_nxt = 1'b0;
    id_nxt    = '0;
    if (nmi_pend_q && !nmi_act_q) begin
      valid_nxt = 1'b1;
      id_nxt    = NMI_ID;
    end else if (found && !nmi_act_q && best_group < run_group) begin
      valid_nxt = 1'b1;
      id_nxt    = best_id;
    end
    if (core_ack) valid_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid_q <= 1'b0;
      req_id_q    <= '0;
      req_tail_q  <= 1'b0;
      exit_seen_q <= 1'b0;
    end else begin
      req_valid_q <= valid_nxt;
      req_id_q    <= id_nxt;
      req_tail_q  <= valid_nxt && exit_seen_q;
      exit_seen_q <= core_exit;
    end
  end

  assign req_valid = req_valid_q;
  assign req_id    = req_id_q;
  assign req_tail  = req_tail_q;
endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker #(
  parameter int NUM_IRQ = 41,
  parameter int ID_W    = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic [ID_W-1:0] req_id,
  input logic            req_tail,
  input logic            core_ack,
  input logic            core_exit,
  input logic            nmi_pend,
  input logic            nmi_act
);
  localparam logic [ID_W-1:0] NMI_ID = ID_W'(NUM_IRQ);

  p_reset_idle_r1: assert property (@(posedge clk) rst |=> (!req_valid && !req_tail));

  p_ack_withdraw_r5: assert property (@(posedge clk) disable iff (rst)
    (core_ack && req_valid) |=> !req_valid);

  p_id_range_r7: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_id <= NMI_ID));

  p_tail_valid_r9: assert property (@(posedge clk) disable iff (rst)
    req_tail |-> req_valid);

  p_tail_cause_r9: assert property (@(posedge clk) disable iff (rst)
    req_tail |-> $past(core_exit, 2));

  p_nmi_first_r10: assert property (@(posedge clk) disable iff (rst)
    (nmi_pend && !nmi_act && !core_ack) |=> (req_valid && req_id == NMI_ID));

  p_nmi_unpreempted_r10: assert property (@(posedge clk) disable iff (rst)
    (nmi_act && !core_exit) |=> !req_valid);
endmodule

bind prio_irq_ctrl irq_ctrl_checker #(.NUM_IRQ(NUM_IRQ), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_id(req_id),
  .req_tail(req_tail), .core_ack(core_ack), .core_exit(core_exit),
  .nmi_pend(nmi_pend_q), .nmi_act(nmi_act_q)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  localparam int N = 8;
  localparam int PW = 4;
  localparam int IW = $clog2(N + 1);
  localparam int VW = 4;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] irq_in = '0;
  logic nmi_in = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_op = 3'd7;
  logic [IW-1:0] wr_num = '0;
  logic [N-1:0] wr_data = '0;
  logic [VW-1:0] wr_val = '0;
  logic core_ack = 1'b0;
  logic core_exit = 1'b0;
  logic [IW-1:0] exit_id = '0;
  logic req_valid, req_tail;
  logic [IW-1:0] req_id;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl #(.NUM_IRQ(N), .PRIO_W(PW)) dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .nmi_in(nmi_in),
    .wr_en(wr_en), .wr_op(wr_op), .wr_num(wr_num), .wr_data(wr_data),
    .wr_val(wr_val), .core_ack(core_ack), .core_exit(core_exit),
    .exit_id(exit_id), .req_valid(req_valid), .req_id(req_id),
    .req_tail(req_tail)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input int op, input int num, input int data, input int val);
    wr_en = 1'b1; wr_op = 3'(op); wr_num = IW'(num);
    wr_data = N'(data); wr_val = VW'(val);
    tick();
    wr_en = 1'b0; wr_op = 3'd7;
  endtask

  task automatic ack();
    core_ack = 1'b1; tick(); core_ack = 1'b0;
  endtask

  task automatic leave(input int id);
    core_exit = 1'b1; exit_id = IW'(id); tick(); core_exit = 1'b0;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // encodes valid/id/tail as valid*1000 + id*10 + tail
  task automatic chk_req(input string tag, input bit v, input int id, input bit t);
    int a, e;
    a = req_valid ? (1000 + int'(req_id) * 10 + int'(req_tail)) : 0;
    e = v ? (1000 + id * 10 + int'(t)) : 0;
    chk(tag, a, e);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    tick(); tick();
    chk_req("R1 reset idle", 0, 0, 0);
    rst = 1'b0;
    tick();
    chk_req("R1 after reset", 0, 0, 0);

    // R11: disabled line pends but is not presented
    wr(0, 0, 'h08, 0); tick();
    chk_req("R11 disabled not presented", 0, 0, 0);
    wr(2, 0, 'h08, 0); tick();
    chk_req("R11 enabled presented", 1, 3, 0);
    // R4: clear pending by mask, trigger by number
    wr(1, 0, 'h08, 0); tick();
    chk_req("R4 clear pending", 0, 0, 0);
    wr(2, 0, 'hFF, 0);
    wr(5, 5, 0, 0); tick();
    chk_req("R4 software trigger", 1, 5, 0);
    wr(1, 0, 'hFF, 0); tick();
    chk_req("R4 cleared all", 0, 0, 0);

    // R7 / R12: pairwise sweep
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        int pi, pj, w, l;
        pi = (i * 3 + j * 5) % 16;
        pj = ((i + j) % 4 == 0) ? pi : (j * 7 + i) % 16;
        w = (pj < pi) ? j : i;
        l = (w == i) ? j : i;
        wr(4, i, 0, pi);
        wr(4, j, 0, pj);
        wr(0, 0, (1 << i) | (1 << j), 0);
        tick();
        chk_req("R7 pair winner", 1, w, 0);
        wr(4, w, 0, 15);
        wr(4, l, 0, 0);
        tick();
        chk_req("R12 reprioritized winner", 1, l, 0);
        wr(1, 0, 'hFF, 0);
        tick();
      end
    end
    chk_req("R4 sweep cleared", 0, 0, 0);

    // R2 / R5: level line
    irq_in[2] = 1'b1; tick(); tick();
    chk_req("R2 level presented", 1, 2, 0);
    ack(); tick();
    chk_req("R5 no re-pend while active", 0, 0, 0);
    irq_in[2] = 1'b0;
    leave(2); tick();
    chk_req("R5 dropped line not re-presented", 0, 0, 0);

    // R6 / R9: still high on exit
    irq_in[4] = 1'b1; tick(); tick();
    chk_req("R2 line 4 presented", 1, 4, 0);
    ack(); tick();
    leave(4); tick();
    chk_req("R6 re-armed on exit with tail", 1, 4, 1);
    ack(); irq_in[4] = 1'b0; leave(4); tick();
    chk_req("R6 idle after drop", 0, 0, 0);

    // R3: rising edge while active
    wr(0, 0, 'h40, 0); tick();
    chk_req("R3 line 6 presented", 1, 6, 0);
    ack();
    irq_in[6] = 1'b1; tick(); irq_in[6] = 1'b0; tick();
    chk_req("R3 same group no preempt", 0, 0, 0);
    leave(6); tick();
    chk_req("R3 edge kept pending", 1, 6, 1);
    ack(); leave(6); tick();
    chk_req("R3 idle", 0, 0, 0);

    // R8: group split 2
    wr(6, 0, 0, 2);
    wr(4, 0, 0, 5); wr(4, 1, 0, 4); wr(4, 2, 0, 3);
    wr(0, 0, 'h01, 0); tick();
    chk_req("R8 line 0 presented", 1, 0, 0);
    ack();
    wr(0, 0, 'h02, 0); tick();
    chk_req("R8 subpriority only no preempt", 0, 0, 0);
    wr(0, 0, 'h04, 0); tick();
    chk_req("R8 lower group preempts", 1, 2, 0);
    ack(); leave(2); tick();
    chk_req("R8 still blocked by line 0", 0, 0, 0);
    leave(0); tick();
    chk_req("R9 tail chain to line 1", 1, 1, 1);
    tick();
    chk_req("R9 tail flag one cycle", 1, 1, 0);
    ack(); leave(1); tick();
    chk_req("R8 idle", 0, 0, 0);
    // R8 clamp: split 7 keeps one group bit
    wr(6, 0, 0, 7);
    wr(4, 0, 0, 8); wr(4, 1, 0, 7);
    wr(0, 0, 'h01, 0); tick();
    ack();
    wr(0, 0, 'h02, 0); tick();
    chk_req("R8 clamped split preempts", 1, 1, 0);
    ack(); leave(1); tick();
    leave(0); tick(); tick();
    chk_req("R8 clamp idle", 0, 0, 0);

    // R10: non-maskable line
    wr(4, 0, 0, 0);
    wr(0, 0, 'h01, 0); tick();
    ack();
    nmi_in = 1'b1; tick(); nmi_in = 1'b0; tick();
    chk_req("R10 nmi over most urgent", 1, N, 0);
    ack();
    nmi_in = 1'b1; tick(); nmi_in = 1'b0; tick();
    chk_req("R10 nothing while nmi active", 0, 0, 0);
    leave(N); tick();
    chk_req("R10 nmi edge kept, tail", 1, N, 1);
    ack(); leave(N); tick();
    chk_req("R10 after nmi, line 0 still active", 0, 0, 0);
    leave(0); tick(); tick();
    chk_req("R10 final idle", 0, 0, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule